// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column addresses of one read burst for a synchronous memory array. A read request arrives with a start address, a burst length of four or eight beats, and an ordering choice: wrapping sequential or XOR-interleaved. The block stores these and presents one address per enabled clock until the burst is complete. Within a burst only the low two or three address bits change. All higher bits stay at the captured start value.

A clock-enable input suspends the sequencer. While it is low, every output and all internal state stay frozen, including the request inputs. When it returns high, the burst continues from the beat where it stopped. A new request accepted during a burst cancels that burst. A request accepted on the final beat chains the next burst with no gap.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears its state. After reset, burst_valid and burst_last are 0 until a request is accepted.
- R2: A request is accepted at a rising edge where clk_en=1 and req=1. After that edge, burst_valid=1 and burst_addr equals the captured req_addr.
- R3: With req_len8=0, the burst has 4 beats. In wrap mode (req_xor=0), bits 1:0 count up by one per beat from the start value and wrap modulo 4, while bit 2 keeps its start value. Example: start low bits 6 gives 6,7,4,5.
- R4: With req_len8=1, the burst has 8 beats. In wrap mode, bits 2:0 count up from the start value modulo 8. Example: start 5 gives 5,6,7,0,1,2,3,4.
- R5: With req_xor=1, the low burst field on beat k equals the start field XOR k. Examples: length 4 from 1 gives 1,0,3,2; length 8 from 5 gives 5,4,7,6,1,0,3,2; length 8 from 7 gives 7 down to 0.
- R6: Address bits 20:3 equal req_addr[20:3] on every beat of the burst.
- R7: At an edge where clk_en=0, burst_addr, burst_valid and burst_last do not change, and req is ignored. After clk_en returns to 1, the burst continues with the next beat of the same sequence.
- R8: burst_last is 1 only on the final beat, together with the final address. After the next enabled edge with no request, burst_valid is 0.
- R9: A request accepted during a burst abandons the remaining beats. The next beat is the first address of the new burst.
- R10: A request accepted on the final beat keeps burst_valid at 1 and starts the new sequence with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Clock enable; 0 suspends and holds all state |
| req | input | 1 | Start a new burst |
| req_addr | input | 21 | Start address of the burst |
| req_len8 | input | 1 | Burst length: 1 = eight beats, 0 = four beats |
| req_xor | input | 1 | Ordering: 1 = interleaved, 0 = wrapping sequential |
| burst_addr | output | 21 | Current burst address |
| burst_valid | output | 1 | burst_addr is a live beat |
| burst_last | output | 1 | Current beat is the final one of the burst |

## Verification
A vector table drives both lengths in both orderings. The start offsets are chosen to separate the orderings: zero, where they give the same sequence; offsets that wrap; and offsets where interleaving runs backwards, such as 7. A length-4 burst from 6 shows whether bit 2 stays out of the count. Varied upper bits expose any carry out of the burst field. Directed runs cover the remaining behaviour: a suspend that lasts several cycles while a request is pending, an abort in the middle of a burst, and a request on the final beat.

// File: rtl/burst_addr_pkg.sv
// Shared types for the burst address sequencer.
// Assumes: both burst lengths are powers of two.
package burst_addr_pkg;
    typedef enum logic {
        ORD_WRAP = 1'b0,
        ORD_XOR  = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic         len_long;
        burst_order_e order;
    } burst_mode_t;
endpackage

// File: rtl/burst_index_ctr.sv
// Beat counter for one burst. It starts at 0 on load, advances on each
// enabled edge and stops after the beat equal to 'lim'.
// Assumes: lim is stable while active, except on the load cycle.
module burst_index_ctr #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             load,
    input  logic [IDX_W-1:0] lim,
    output logic [IDX_W-1:0] idx,
    output logic             active,
    output logic             at_end
);
    // final beat reached
    assign at_end = active && (idx == lim);

    // beat index and live flag, frozen while clk_en is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            active <= 1'b0;
        end else if (clk_en) begin
            if (load) begin
                idx    <= '0;
                active <= 1'b1;
            end else if (at_end) begin
                idx    <= '0;
                active <= 1'b0;
            end else if (active) begin
                idx    <= idx + 1'b1;
            end
        end
    end

    p_idx_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx <= lim));
endmodule

// File: rtl/burst_addr_map.sv
// Combinational address former. It combines the stored base address with
// the beat index, using wrapping or XOR order inside the burst field.
// Assumes: mask is 2^n-1 and covers at most IDX_W bits; idx <= mask.
module burst_addr_map
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int IDX_W  = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic [IDX_W-1:0]  mask,
    input  burst_order_e      order,
    output logic [ADDR_W-1:0] addr
);
    logic [IDX_W-1:0] low;
    logic [IDX_W-1:0] wrap_low;
    logic [IDX_W-1:0] xor_low;

    // both orderings, restricted to the active burst field
    always_comb begin
        low      = base[IDX_W-1:0];
        wrap_low = (low & ~mask) | ((low + idx) & mask);
        xor_low  = low ^ (idx & mask);
    end

    // select the ordering; upper bits pass straight through
    always_comb begin
        addr = base;
        addr[IDX_W-1:0] = (order == ORD_XOR) ? xor_low : wrap_low;
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Burst column address sequencer top. It captures the request, runs the
// beat counter and forms one address per enabled clock.
// Assumes: req is sampled only when clk_en is high; reset is synchronous.
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W    = 21,
    parameter int SHORT_LEN = 4,
    parameter int LONG_LEN  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_len8,
    input  logic              req_xor,
    output logic [ADDR_W-1:0] burst_addr,
    output logic              burst_valid,
    output logic              burst_last
);
    localparam int FLD_W = $clog2(LONG_LEN);
    localparam logic [FLD_W-1:0] SHORT_MASK = FLD_W'(SHORT_LEN - 1);
    localparam logic [FLD_W-1:0] LONG_MASK  = FLD_W'(LONG_LEN - 1);

    logic [ADDR_W-1:0] base_q;
    burst_mode_t       mode_q;
    logic [FLD_W-1:0]  idx;
    logic [FLD_W-1:0]  mask;
    logic              load;

    assign load = clk_en && req;
    assign mask = mode_q.len_long ? LONG_MASK : SHORT_MASK;

    // capture request address and mode when a burst is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mode_q <= '{len_long: 1'b0, order: ORD_WRAP};
        end else if (load) begin
            base_q <= req_addr;
            mode_q <= '{len_long: req_len8, order: burst_order_e'(req_xor)};
        end
    end

    burst_index_ctr #(.IDX_W(FLD_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .load   (load),
        .lim    (mask),
        .idx    (idx),
        .active (burst_valid),
        .at_end (burst_last)
    );

    burst_addr_map #(.ADDR_W(ADDR_W), .IDX_W(FLD_W)) u_map (
        .base  (base_q),
        .idx   (idx),
        .mask  (mask),
        .order (mode_q.order),
        .addr  (burst_addr)
    );

    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && req) |=> (burst_valid && burst_addr == $past(req_addr)));

    p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !req && burst_valid && !burst_last)
        |=> $stable(burst_addr[ADDR_W-1:FLD_W]));

    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(burst_addr) && $stable(burst_valid) && $stable(burst_last)));

    p_last_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && burst_last && !req) |=> !burst_valid);

    p_chain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && burst_last && req) |=> burst_valid);
endmodule

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
    localparam int AW = 21;

    typedef struct packed {
        logic          len8;
        logic          ilv;
        logic [AW-1:0] addr;
        logic [23:0]   exp;   // eight 3-bit low fields, beat 0 in [23:21]
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{1'b0, 1'b0, 21'h12342, {3'd2,3'd3,3'd0,3'd1,12'd0}},                   // R3 wrap 2,3,0,1
        '{1'b0, 1'b0, 21'h0F0F6, {3'd6,3'd7,3'd4,3'd5,12'd0}},                   // R3 bit2 kept
        '{1'b1, 1'b0, 21'h1FFFD, {3'd5,3'd6,3'd7,3'd0,3'd1,3'd2,3'd3,3'd4}},     // R4
        '{1'b1, 1'b0, 21'h00000, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7}},     // R4
        '{1'b0, 1'b1, 21'h00001, {3'd1,3'd0,3'd3,3'd2,12'd0}},                   // R5
        '{1'b1, 1'b1, 21'h15555, {3'd5,3'd4,3'd7,3'd6,3'd1,3'd0,3'd3,3'd2}},     // R5
        '{1'b1, 1'b1, 21'h0AAAF, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}},     // R5
        '{1'b0, 1'b1, 21'h1C3A6, {3'd6,3'd7,3'd4,3'd5,12'd0}}                    // R5
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b1;
    logic          req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_len8 = 1'b0;
    logic          req_xor = 1'b0;
    logic [AW-1:0] burst_addr;
    logic          burst_valid;
    logic          burst_last;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    burst_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .req(req),
        .req_addr(req_addr), .req_len8(req_len8), .req_xor(req_xor),
        .burst_addr(burst_addr), .burst_valid(burst_valid), .burst_last(burst_last)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic beat(input string tag, input logic [AW-1:0] a, input logic last);
        chk({tag, " addr"}, 32'(burst_addr), 32'(a));
        chk({tag, " valid"}, 32'(burst_valid), 32'd1);
        chk({tag, " last R8"}, 32'(burst_last), 32'(last));
    endtask

    task automatic issue(input logic [AW-1:0] a, input logic l8, input logic x);
        req = 1'b1; req_addr = a; req_len8 = l8; req_xor = x;
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(burst_valid), 0);
        chk("R1 last in reset", 32'(burst_last), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", 32'(burst_valid), 0);
        chk("R1 last after reset", 32'(burst_last), 0);

        // R2..R6, R8: table walk
        foreach (TBL[v]) begin
            automatic int n = TBL[v].len8 ? 8 : 4;
            issue(TBL[v].addr, TBL[v].len8, TBL[v].ilv);
            for (int i = 0; i < n; i++) begin
                automatic logic [2:0] lo = TBL[v].exp[23-3*i -: 3];
                @(negedge clk);
                req = 1'b0;
                beat($sformatf("R2-R6 vec%0d beat%0d", v, i),
                     {TBL[v].addr[AW-1:3], lo}, i == n - 1);
            end
            @(negedge clk);
            chk($sformatf("R8 vec%0d idle", v), 32'(burst_valid), 0);
        end

        // R7: suspend holds state and ignores req
        issue(21'h00100, 1'b1, 1'b0);
        @(negedge clk); req = 1'b0; beat("R7 pre0", 21'h00100, 0);
        @(negedge clk); beat("R7 pre1", 21'h00101, 0);
        clk_en = 1'b0;
        issue(21'h1FFFF, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            beat("R7 frozen", 21'h00101, 0);
        end
        clk_en = 1'b1; req = 1'b0;
        for (int i = 2; i < 8; i++) begin
            @(negedge clk);
            beat("R7 resume", 21'(32'h100 + i), i == 7);
        end
        @(negedge clk);
        chk("R7 end idle", 32'(burst_valid), 0);

        // R9: abort mid-burst
        issue(21'h00200, 1'b1, 1'b0);
        @(negedge clk); req = 1'b0; beat("R9 old0", 21'h00200, 0);
        @(negedge clk); beat("R9 old1", 21'h00201, 0);
        issue(21'h00301, 1'b0, 1'b1);
        @(negedge clk); req = 1'b0; beat("R9 new0", 21'h00301, 0);
        @(negedge clk); beat("R9 new1", 21'h00300, 0);
        @(negedge clk); beat("R9 new2", 21'h00303, 0);
        @(negedge clk); beat("R9 new3", 21'h00302, 1);
        @(negedge clk);
        chk("R9 idle", 32'(burst_valid), 0);

        // R10: chained request on the final beat
        issue(21'h00400, 1'b0, 1'b0);
        @(negedge clk); req = 1'b0; beat("R10 a0", 21'h00400, 0);
        @(negedge clk); beat("R10 a1", 21'h00401, 0);
        @(negedge clk); beat("R10 a2", 21'h00402, 0);
        @(negedge clk); beat("R10 a3", 21'h00403, 1);
        issue(21'h00505, 1'b1, 1'b1);
        begin
            automatic logic [2:0] seq [8] = '{3'd5, 3'd4, 3'd7, 3'd6, 3'd1, 3'd0, 3'd3, 3'd2};
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                req = 1'b0;
                beat("R10 b", {18'h000A0, seq[i]}, i == 7);
            end
        end
        @(negedge clk);
        chk("R10 idle", 32'(burst_valid), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule